// File: doc/BRIEF.md
# I/O Address Translation Table Walker

This block turns a 64-bit device virtual address into a physical address by walking a radix tree of translation tables held in memory. A request gives the virtual address, the physical address of the root table and the level of that root. The walker then reads one 64-bit entry per level through a simple memory read port. That port has a request handshake and a response strobe, and the response may come back after any number of cycles. When the walk ends, the walker presents a result: the physical address, read and write permission, a force-coherent flag and a fault flag. The result stays on the outputs until the consumer takes it.

Each table holds 512 entries of 8 bytes, so each level consumes 9 bits of the virtual address. The levels run from 0 up to 5. An entry can point to a further table, or it can be a leaf. A leaf either covers exactly the span of one item at its level, or it carries its page size inside its frame field. The size is given by the position of the frame field's lowest clear bit.

The control is a four-state machine with these states:
- `ST_IDLE`: waiting for a request.
- `ST_ISSUE`: presenting an entry read.
- `ST_WAIT`: waiting for the read data.
- `ST_DONE`: holding the result.

The transitions are:
- accept: `ST_IDLE` to `ST_ISSUE`.
- reject: `ST_IDLE` to `ST_DONE`, taken when the top level is out of range.
- sent: `ST_ISSUE` to `ST_WAIT`, when the read is taken.
- descend: `ST_WAIT` to `ST_ISSUE`, when a pointer entry arrives.
- finish: `ST_WAIT` to `ST_DONE`, when a leaf arrives or a fault is found.
- retire: `ST_DONE` to `ST_IDLE`, when the result is taken.

Top module: `ptw_walker`

## Requirements
- R1: After reset the walker is idle. `req_ready` is 1, and `mem_req_valid` and `res_valid` are 0.
- R2: A request whose `req_top` is greater than 5 issues no memory read. Its faulting result appears on the outputs in the cycle right after the request is accepted.
- R3: The walker makes one entry read per level visited. Its address is the current table base plus 8 times the index. The index is virtual address bits [12+9L+8 : 12+9L] for level L. At level 5 only bits 63:57 exist, and the missing upper index bits read as zero. The low 12 bits of `req_root` are ignored.
- R4: An entry whose bit 0 (present) is clear ends the walk with a fault.
- R5: An entry found above level 0 with bits 11:9 in the range 1 to 6 is a pointer. The next read comes from the table at (bits 51:12) × 4096, one level lower.
- R6: An entry with bits 11:9 equal to 0, or any present entry found at level 0, is a plain leaf. The physical address is (bits 51:12) × 4096, with every bit below 12+9L replaced by the matching virtual address bit.
- R7: An entry with bits 11:9 equal to 7 is a sized leaf. Let z be the lowest clear bit of its frame field (entry bits 51:12). The page is 2^(z+13) bytes. The physical address is the frame shifted left by 12, with every bit below z+13 replaced by the matching virtual address bit. A frame field with no clear bit is a fault.
- R8: A leaf-type entry (code 0 or 7) read at level 5 is a fault.
- R9: `res_read` is the AND of bit 61 of every entry read in the walk, and `res_write` is the AND of bit 62. `res_coherent` is bit 60 of the leaf.
- R10: A faulting result has `res_fault` set, with `res_pa` equal to 0 and the read, write and coherent outputs all 0.
- R11: A request is taken only while `req_ready` is 1, and request inputs are ignored at any other time. A pending read keeps `mem_req_valid` and `mem_req_addr` unchanged until `mem_req_ready`. No second read starts before the response arrives. A result stays valid and unchanged until `res_ready`.
- R12: Entry data is decoded only in the cycle `mem_rsp_valid` is 1, so any read latency gives the same result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request strobe |
| req_ready | output | 1 | Walker is idle and takes a request |
| req_va | input | 64 | Virtual address to translate |
| req_root | input | 52 | Physical address of the root table |
| req_top | input | 3 | Level of the root table |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory takes the read |
| mem_req_addr | output | 52 | Byte address of the entry |
| mem_rsp_valid | input | 1 | Read data strobe |
| mem_rsp_data | input | 64 | Entry read from memory |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Consumer takes the result |
| res_pa | output | 52 | Translated physical address |
| res_read | output | 1 | Read allowed |
| res_write | output | 1 | Write allowed |
| res_coherent | output | 1 | Force-coherent flag of the leaf |
| res_fault | output | 1 | Translation fault |

## Verification
The checker assumes the memory side gives exactly one `mem_rsp_valid` pulse for each read it has accepted, and none at any other time. Its outstanding-read tracking relies on this. It also assumes `req_top` is stable in the cycle a request is accepted. The bench's memory model answers only after it has raised `mem_req_ready` for a read. It gives a single response per read, after a stall and a latency that change from walk to walk. Request fields are driven once per walk and held until acceptance.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_DONE
    } walk_state_e;

    localparam int unsigned ENTRY_W   = 64;
    localparam int unsigned ENTRY_LG2 = 3;   // bytes per entry = 2^3
    localparam int unsigned POS_VALID = 0;
    localparam int unsigned POS_CODE  = 9;
    localparam int unsigned CODE_W    = 3;
    localparam int unsigned POS_COH   = 60;
    localparam int unsigned POS_RD    = 61;
    localparam int unsigned POS_WR    = 62;

    localparam logic [CODE_W-1:0] CODE_PLAIN = 3'd0;
    localparam logic [CODE_W-1:0] CODE_SIZED = 3'd7;

endpackage

// File: rtl/ptw_low_zero.sv
module ptw_low_zero #(
    parameter int W     = 40,
    parameter int POS_W = 6
) (
    input  logic [W-1:0]     vec,
    output logic [POS_W-1:0] pos,
    output logic             found
);

    // Scan from the top so the last hit is the lowest clear bit.
    always_comb begin
        pos   = '0;
        found = 1'b0;
        for (int i = W - 1; i >= 0; i--) begin
            if (!vec[i]) begin
                pos   = POS_W'(i);
                found = 1'b1;
            end
        end
    end

endmodule

// File: rtl/ptw_entry_decode.sv
module ptw_entry_decode
    import ptw_pkg::*;
#(
    parameter int PA_W     = 52,
    parameter int PG_SHIFT = 12,
    parameter int LVL_W    = 3
) (
    input  logic [ENTRY_W-1:0]       entry,
    input  logic [LVL_W-1:0]         level,
    output logic                     present,
    output logic                     leaf,
    output logic                     sized,
    output logic [PA_W-PG_SHIFT-1:0] frame,
    output logic                     coh,
    output logic                     rd,
    output logic                     wr
);

    localparam int FRM_W = PA_W - PG_SHIFT;

    logic [CODE_W-1:0] code;
    logic              unused_bits;

    always_comb begin
        code    = entry[POS_CODE +: CODE_W];
        present = entry[POS_VALID];
        frame   = entry[PG_SHIFT +: FRM_W];
        coh     = entry[POS_COH];
        rd      = entry[POS_RD];
        wr      = entry[POS_WR];
        sized   = (code == CODE_SIZED);
        leaf    = (level == '0) || (code == CODE_PLAIN) || sized;
    end

    assign unused_bits = ^{entry[ENTRY_W-1], entry[POS_COH-1:PA_W], entry[POS_CODE-1:1]};

endmodule

// File: rtl/ptw_addr_form.sv
module ptw_addr_form #(
    parameter int PA_W     = 52,
    parameter int PG_SHIFT = 12,
    parameter int IDX_W    = 9,
    parameter int LVL_W    = 3,
    parameter int POS_W    = 6
) (
    input  logic [PA_W-PG_SHIFT-1:0] frame,
    input  logic [PA_W-1:0]          va_lo,
    input  logic [LVL_W-1:0]         level,
    input  logic                     sized,
    input  logic [POS_W-1:0]         zpos,
    output logic [PA_W-1:0]          pa
);

    localparam int SH_W = 8;

    logic [SH_W-1:0] span_lg2;
    logic [PA_W-1:0] off_mask;

    always_comb begin
        if (sized)
            span_lg2 = SH_W'(zpos) + SH_W'(PG_SHIFT + 1);
        else
            span_lg2 = SH_W'(PG_SHIFT) + SH_W'(IDX_W) * SH_W'(level);

        if (span_lg2 >= SH_W'(PA_W))
            off_mask = '1;
        else
            off_mask = (PA_W'(1) << span_lg2) - PA_W'(1);

        pa = ({frame, {PG_SHIFT{1'b0}}} & ~off_mask) | (va_lo & off_mask);
    end

endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
    import ptw_pkg::*;
#(
    parameter int VA_W     = 64,
    parameter int PA_W     = 52,
    parameter int PG_SHIFT = 12,
    parameter int IDX_W    = 9,
    parameter int LVL_W    = 3,
    parameter int MAX_LVL  = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [VA_W-1:0]     req_va,
    input  logic [PA_W-1:0]     req_root,
    input  logic [LVL_W-1:0]    req_top,
    output logic                mem_req_valid,
    input  logic                mem_req_ready,
    output logic [PA_W-1:0]     mem_req_addr,
    input  logic                mem_rsp_valid,
    input  logic [ENTRY_W-1:0]  mem_rsp_data,
    output logic                res_valid,
    input  logic                res_ready,
    output logic [PA_W-1:0]     res_pa,
    output logic                res_read,
    output logic                res_write,
    output logic                res_coherent,
    output logic                res_fault
);

    localparam int FRM_W = PA_W - PG_SHIFT;
    localparam int POS_W = $clog2(FRM_W);
    localparam int SA_W  = 8;

    walk_state_e st_q, st_d;

    logic [VA_W-1:0]  va_q;
    logic [PA_W-1:0]  base_q;
    logic [LVL_W-1:0] lvl_q;
    logic             rd_acc_q, wr_acc_q;
    logic [PA_W-1:0]  out_pa_q;
    logic             out_rd_q, out_wr_q, out_coh_q, out_flt_q;

    logic [SA_W-1:0]  idx_shift;
    logic [VA_W-1:0]  va_shifted;
    logic [IDX_W-1:0] idx;

    logic             dec_present, dec_leaf, dec_sized, dec_coh, dec_rd, dec_wr;
    logic [FRM_W-1:0] dec_frame;
    logic [POS_W-1:0] z_pos;
    logic             z_any;
    logic [PA_W-1:0]  leaf_pa;

    logic top_bad, at_top, walk_end, walk_fault;

    ptw_entry_decode #(
        .PA_W(PA_W), .PG_SHIFT(PG_SHIFT), .LVL_W(LVL_W)
    ) u_dec (
        .entry   (mem_rsp_data),
        .level   (lvl_q),
        .present (dec_present),
        .leaf    (dec_leaf),
        .sized   (dec_sized),
        .frame   (dec_frame),
        .coh     (dec_coh),
        .rd      (dec_rd),
        .wr      (dec_wr)
    );

    ptw_low_zero #(
        .W(FRM_W), .POS_W(POS_W)
    ) u_lz (
        .vec   (dec_frame),
        .pos   (z_pos),
        .found (z_any)
    );

    ptw_addr_form #(
        .PA_W(PA_W), .PG_SHIFT(PG_SHIFT), .IDX_W(IDX_W),
        .LVL_W(LVL_W), .POS_W(POS_W)
    ) u_form (
        .frame (dec_frame),
        .va_lo (va_q[PA_W-1:0]),
        .level (lvl_q),
        .sized (dec_sized),
        .zpos  (z_pos),
        .pa    (leaf_pa)
    );

    // Entry index and walk decisions
    always_comb begin
        idx_shift  = SA_W'(PG_SHIFT) + SA_W'(IDX_W) * SA_W'(lvl_q);
        va_shifted = va_q >> idx_shift;
        idx        = va_shifted[IDX_W-1:0];
        top_bad    = (req_top > LVL_W'(MAX_LVL));
        at_top     = (lvl_q == LVL_W'(MAX_LVL));
        walk_end   = !dec_present || dec_leaf;
        walk_fault = !dec_present ||
                     (dec_leaf && (at_top || (dec_sized && !z_any)));
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= ST_IDLE;
        else
            st_q <= st_d;
    end

    // Next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:  if (req_valid)      st_d = top_bad ? ST_DONE : ST_ISSUE;
            ST_ISSUE: if (mem_req_ready)  st_d = ST_WAIT;
            ST_WAIT:  if (mem_rsp_valid)  st_d = walk_end ? ST_DONE : ST_ISSUE;
            ST_DONE:  if (res_ready)      st_d = ST_IDLE;
            default:                      st_d = ST_IDLE;
        endcase
    end

    // Walk context and result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            va_q      <= '0;
            base_q    <= '0;
            lvl_q     <= '0;
            rd_acc_q  <= 1'b0;
            wr_acc_q  <= 1'b0;
            out_pa_q  <= '0;
            out_rd_q  <= 1'b0;
            out_wr_q  <= 1'b0;
            out_coh_q <= 1'b0;
            out_flt_q <= 1'b0;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        va_q     <= req_va;
                        base_q   <= {req_root[PA_W-1:PG_SHIFT], {PG_SHIFT{1'b0}}};
                        lvl_q    <= req_top;
                        rd_acc_q <= 1'b1;
                        wr_acc_q <= 1'b1;
                        if (top_bad) begin
                            out_pa_q  <= '0;
                            out_rd_q  <= 1'b0;
                            out_wr_q  <= 1'b0;
                            out_coh_q <= 1'b0;
                            out_flt_q <= 1'b1;
                        end
                    end
                end
                ST_WAIT: begin
                    if (mem_rsp_valid) begin
                        if (walk_fault) begin
                            out_pa_q  <= '0;
                            out_rd_q  <= 1'b0;
                            out_wr_q  <= 1'b0;
                            out_coh_q <= 1'b0;
                            out_flt_q <= 1'b1;
                        end else if (walk_end) begin
                            out_pa_q  <= leaf_pa;
                            out_rd_q  <= rd_acc_q && dec_rd;
                            out_wr_q  <= wr_acc_q && dec_wr;
                            out_coh_q <= dec_coh;
                            out_flt_q <= 1'b0;
                        end else begin
                            base_q   <= {dec_frame, {PG_SHIFT{1'b0}}};
                            lvl_q    <= lvl_q - LVL_W'(1);
                            rd_acc_q <= rd_acc_q && dec_rd;
                            wr_acc_q <= wr_acc_q && dec_wr;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        req_ready     = (st_q == ST_IDLE);
        mem_req_valid = (st_q == ST_ISSUE);
        res_valid     = (st_q == ST_DONE);
        mem_req_addr  = base_q | PA_W'({idx, {ENTRY_LG2{1'b0}}});
        res_pa        = out_pa_q;
        res_read      = out_rd_q;
        res_write     = out_wr_q;
        res_coherent  = out_coh_q;
        res_fault     = out_flt_q;
    end

endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk #(
    parameter int PA_W    = 52,
    parameter int LVL_W   = 3,
    parameter int MAX_LVL = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic [LVL_W-1:0] req_top,
    input logic             mem_req_valid,
    input logic             mem_req_ready,
    input logic [PA_W-1:0]  mem_req_addr,
    input logic             mem_rsp_valid,
    input logic             res_valid,
    input logic             res_ready,
    input logic [PA_W-1:0]  res_pa,
    input logic             res_read,
    input logic             res_write,
    input logic             res_coherent,
    input logic             res_fault
);

    logic rd_pending;

    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_pending <= 1'b0;
        else if (mem_req_valid && mem_req_ready)
            rd_pending <= 1'b1;
        else if (mem_rsp_valid)
            rd_pending <= 1'b0;
    end

    // R11
    mem_req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

    // R11
    single_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_pending |-> !mem_req_valid);

    // R11
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && !res_ready |=> res_valid &&
            $stable({res_pa, res_read, res_write, res_coherent, res_fault}));

    // R11
    idle_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !mem_req_valid && !res_valid);

    // R2
    bad_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && (req_top > LVL_W'(MAX_LVL)) |=> res_valid && res_fault);

    // R10
    fault_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && res_fault |-> (res_pa == '0) && !res_read && !res_write && !res_coherent);

    // R12
    result_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(res_valid) |-> $past(mem_rsp_valid) ||
            $past(req_valid && req_ready && (req_top > LVL_W'(MAX_LVL))));

endmodule

bind ptw_walker ptw_walker_chk #(
    .PA_W(PA_W), .LVL_W(LVL_W), .MAX_LVL(MAX_LVL)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_top       (req_top),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .res_valid     (res_valid),
    .res_ready     (res_ready),
    .res_pa        (res_pa),
    .res_read      (res_read),
    .res_write     (res_write),
    .res_coherent  (res_coherent),
    .res_fault     (res_fault)
);

// File: tb/tb_ptw_walker.sv
module tb_ptw_walker;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 9;

    typedef struct packed {
        logic [63:0] va;
        logic [51:0] root;
        logic [2:0]  top;
        logic [51:0] pa;
        logic        r;
        logic        w;
        logic        c;
        logic        f;
        logic [7:0]  reads;
    } vec_t;

    // va, root, top, expected pa, read, write, coherent, fault, reads
    localparam vec_t VECS [NVEC] = '{
        '{64'h0000_0000_4060_5ABC, 52'h103000, 3'd2, 52'h0_0000_1234_5ABC, 1'b1, 1'b1, 1'b1, 1'b0, 8'd3},
        '{64'h0000_0000_80A1_2345, 52'h103000, 3'd2, 52'h0_0000_4001_2345, 1'b1, 1'b0, 1'b0, 1'b0, 8'd2},
        '{64'h0000_0000_C000_0000, 52'h103000, 3'd2, 52'h0,                1'b0, 1'b0, 1'b0, 1'b1, 8'd1},
        '{64'h0000_0000_4060_6ABC, 52'h103000, 3'd2, 52'h0_0000_8888_2ABC, 1'b1, 1'b1, 1'b0, 1'b0, 8'd3},
        '{64'h0000_0000_4060_5ABC, 52'h103000, 3'd6, 52'h0,                1'b0, 1'b0, 1'b0, 1'b1, 8'd0},
        '{64'h8000_0000_0000_0000, 52'h100000, 3'd5, 52'h0,                1'b0, 1'b0, 1'b0, 1'b1, 8'd1},
        '{64'hFFFF_FFFF_FFFF_F123, 52'h100000, 3'd5, 52'h0_0003_FFFF_F123, 1'b1, 1'b1, 1'b1, 1'b0, 8'd3},
        '{64'h0000_0000_00E0_0000, 52'h104000, 3'd1, 52'h0,                1'b0, 1'b0, 1'b0, 1'b1, 8'd1},
        '{64'h0000_0000_0000_87FF, 52'h105ABC, 3'd0, 52'h0_0000_5555_57FF, 1'b0, 1'b1, 1'b0, 1'b0, 8'd1}
    };

    function automatic string vec_tags(input int i);
        case (i)
            0: vec_tags = "R3 R5 R6 R9";
            1: vec_tags = "R5 R6 R9";
            2: vec_tags = "R4 R10";
            3: vec_tags = "R7";
            4: vec_tags = "R2";
            5: vec_tags = "R8";
            6: vec_tags = "R3 R7 R9";
            7: vec_tags = "R7 R10";
            default: vec_tags = "R3 R6";
        endcase
    endfunction

    logic        clk;
    logic        rst_n;
    logic        req_valid;
    logic        req_ready;
    logic [63:0] req_va;
    logic [51:0] req_root;
    logic [2:0]  req_top;
    logic        mem_req_valid;
    logic        mem_req_ready;
    logic [51:0] mem_req_addr;
    logic        mem_rsp_valid;
    logic [63:0] mem_rsp_data;
    logic        res_valid;
    logic        res_ready;
    logic [51:0] res_pa;
    logic        res_read;
    logic        res_write;
    logic        res_coherent;
    logic        res_fault;

    int checks = 0;
    int fails  = 0;
    int read_cnt = 0;
    int stall_cyc = 0;
    int lat_cyc = 0;

    logic [63:0] mem_img [logic [51:0]];

    ptw_walker dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_va        (req_va),
        .req_root      (req_root),
        .req_top       (req_top),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_addr  (mem_req_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .res_valid     (res_valid),
        .res_ready     (res_ready),
        .res_pa        (res_pa),
        .res_read      (res_read),
        .res_write     (res_write),
        .res_coherent  (res_coherent),
        .res_fault     (res_fault)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "R12", "watchdog expired", 64'd100000, 64'd0);
        finish_run();
    end

    // Memory model: one read at a time, stall before accept, latency before data
    initial begin
        mem_req_ready = 1'b0;
        mem_rsp_valid = 1'b0;
        mem_rsp_data  = '0;
        forever begin
            @(negedge clk);
            if (mem_req_valid) begin
                logic [51:0] a;
                repeat (stall_cyc) @(negedge clk);
                a = mem_req_addr;
                mem_req_ready = 1'b1;
                @(negedge clk);
                mem_req_ready = 1'b0;
                read_cnt++;
                repeat (lat_cyc) @(negedge clk);
                mem_rsp_data  = mem_img.exists(a) ? mem_img[a] : 64'h0;
                mem_rsp_valid = 1'b1;
                @(negedge clk);
                mem_rsp_valid = 1'b0;
                mem_rsp_data  = 64'hDEAD_BEEF_DEAD_BEEF;
            end
        end
    end

    // Start a walk and return once the result is visible (not yet retired)
    task automatic start_walk(input vec_t v, output int waited, output bit timed_out);
        @(negedge clk);
        req_valid = 1'b1;
        req_va    = v.va;
        req_root  = v.root;
        req_top   = v.top;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        req_va    = '0;
        waited    = 0;
        timed_out = 1'b0;
        while (!res_valid && waited < 2000) begin
            waited++;
            @(negedge clk);
        end
        if (!res_valid) timed_out = 1'b1;
    endtask

    task automatic retire();
        res_ready = 1'b1;
        @(negedge clk);
        res_ready = 1'b0;
    endtask

    function automatic logic [63:0] pack_res();
        return {8'h0, res_fault, res_coherent, res_write, res_read, res_pa};
    endfunction

    function automatic logic [63:0] pack_exp(input vec_t v);
        return {8'h0, v.f, v.c, v.w, v.r, v.pa};
    endfunction

    initial begin
        int waited;
        bit to;
        int rc0;
        req_valid = 1'b0;
        req_va    = '0;
        req_root  = '0;
        req_top   = '0;
        res_ready = 1'b0;
        rst_n     = 1'b0;

        // Table images: T5=0x100000 T4=0x101000 T3=0x102000 T2=0x103000 T1=0x104000 T0=0x105000
        mem_img[52'h100200] = 64'h6000_0000_1234_5001;  // plain leaf at level 5
        mem_img[52'h1003F8] = 64'h6000_0000_0010_1201;  // pointer to T4
        mem_img[52'h101FF8] = 64'h6000_0000_0010_2201;  // pointer to T3
        mem_img[52'h102FF8] = 64'h7000_0003_7FFF_FE01;  // 4 GiB sized leaf
        mem_img[52'h103008] = 64'h6000_0000_0010_4201;  // pointer to T1, RW
        mem_img[52'h103010] = 64'h2000_0000_0010_4201;  // pointer to T1, read only
        mem_img[52'h104018] = 64'h6000_0000_0010_5201;  // pointer to T0
        mem_img[52'h104028] = 64'h6000_0000_4000_7001;  // 2 MiB plain leaf, low frame bits set
        mem_img[52'h104038] = 64'h600F_FFFF_FFFF_FE01;  // sized leaf, frame all ones
        mem_img[52'h105028] = 64'h7000_0000_1234_5001;  // 4 KiB leaf, coherent
        mem_img[52'h105030] = 64'h6000_0000_8888_1E01;  // 16 KiB sized leaf
        mem_img[52'h105040] = 64'h4000_0000_5555_5601;  // level 0 leaf, code 3, write only

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: idle after reset
        chk(req_ready && !mem_req_valid && !res_valid, "R1", "reset state",
            {61'h0, req_ready, mem_req_valid, res_valid}, 64'h4);

        for (int i = 0; i < NVEC; i++) begin
            stall_cyc = i % 3;
            lat_cyc   = i % 4;
            rc0 = read_cnt;
            start_walk(VECS[i], waited, to);
            chk(!to, vec_tags(i), $sformatf("vector %0d result present", i),
                {63'h0, res_valid}, 64'h1);
            chk(pack_res() == pack_exp(VECS[i]), vec_tags(i),
                $sformatf("vector %0d result", i), pack_res(), pack_exp(VECS[i]));
            if (VECS[i].top > 3'd5)
                // R2: result visible one cycle after acceptance
                chk(waited == 0, "R2", "reject latency", 64'(waited), 64'd0);
            retire();
            // R3: one read per level visited (R2: none for a bad top)
            chk(read_cnt - rc0 == int'(VECS[i].reads), "R3", $sformatf("vector %0d read count", i),
                64'(read_cnt - rc0), 64'(VECS[i].reads));
        end

        // R11: result held while res_ready is low; new requests ignored while busy
        begin
            logic [63:0] snap;
            bit ok;
            stall_cyc = 1;
            lat_cyc   = 2;
            start_walk(VECS[0], waited, to);
            snap = pack_res();
            ok   = res_valid;
            for (int k = 0; k < 4; k++) begin
                req_valid = 1'b1;
                req_va    = 64'h0;
                req_top   = 3'd6;
                @(negedge clk);
                ok = ok && res_valid && !req_ready && (pack_res() == snap);
            end
            chk(ok && snap == pack_exp(VECS[0]), "R11", "result held under backpressure",
                pack_res(), pack_exp(VECS[0]));
            req_valid = 1'b0;
            retire();
            @(negedge clk);
            chk(!res_valid && !mem_req_valid && req_ready, "R11", "busy request ignored",
                {61'h0, req_ready, mem_req_valid, res_valid}, 64'h4);
        end

        // R12: long memory latency leaves the result unchanged
        stall_cyc = 3;
        lat_cyc   = 20;
        start_walk(VECS[8], waited, to);
        chk(waited >= 20, "R12", "no result before data", 64'(waited), 64'd20);
        chk(pack_res() == pack_exp(VECS[8]), "R12", "long latency result",
            pack_res(), pack_exp(VECS[8]));
        retire();

        // R6 with zero latency and no stall on a three-level walk
        stall_cyc = 0;
        lat_cyc   = 0;
        start_walk(VECS[0], waited, to);
        chk(pack_res() == pack_exp(VECS[0]), "R6", "zero latency walk",
            pack_res(), pack_exp(VECS[0]));
        retire();

        finish_run();
    end

endmodule